// File: doc/BRIEF.md
# Serial NOR Flash Page Program Sequencer

This block sits on the host side of a serial NOR flash link. It turns one write request into the full bus sequence needed to put up to one page of bytes into the array. A request gives a flavour, a 24-bit start address and a byte count. The payload bytes arrive on a valid/ready byte stream. For each accepted request the sequencer does four things in order:

1. It opens a chip-select window for the one-byte write-enable command.
2. It opens a second window for the program command, the address and the payload.
3. It polls the status register, one window per poll, until the busy flag clears.
4. It reports completion.

Three flavours share the same command byte lane, DQ0:

- **Flavour 0** uses one line throughout.
- **Flavour 1** keeps the address on one line and moves the payload onto two lines.
- **Flavour 2** puts both the address and the payload on two lines.

A request is checked before anything reaches the bus. Any of the following is refused with an error pulse:

- the byte count is zero;
- the byte count is above 256;
- the payload would run past the end of its 256-byte page;
- the flavour code is unused.

Because the flash can only clear bits, the sequencer never tries to raise a bit. It simply sends the bytes it is given.

Top module: `flash_prog_seq`

## Requirements
- R1: Each accepted request first sends opcode 06h alone in its own chip-select window, and only then opens the program window.
- R2: The program window starts with an opcode on DQ0 only, chosen by `req_mode`: 0 gives 02h, 1 gives A2h and 2 gives D2h. Three address bytes follow, most significant byte first, and each byte is sent most significant bit first.
- R3: Address bytes use one line (DQ0) in modes 0 and 1. In mode 2 they use two lines. On two lines DQ1 carries the higher bit of each bit pair.
- R4: The sequencer takes exactly `req_len` bytes from the write stream, in order, and only while chip select is low. Mode 0 sends them on DQ0. Modes 1 and 2 send them on two lines, with DQ1 carrying the higher bit. A pause in `wr_valid` only stretches the window.
- R5: A request is refused when `req_len` is 0, `req_len` is above 256, `req_addr[7:0] + req_len` is above 256, or `req_mode` is 3. A refusal raises `req_err` for one cycle, starts no chip-select window and takes no stream byte.
- R6: After the program window closes, the sequencer repeats status reads, each in its own window: opcode 05h on DQ0, then one byte sampled from `spi_miso` most significant bit first. It stops when bit 0 reads 0 and ignores every other status bit.
- R7: `req_ready` is high only while the block is idle. `req_done` pulses for one cycle after the status read that shows bit 0 clear. No other command starts while that bit is set.
- R8: After reset, `spi_cs_n` is high, `spi_sck` is low, `req_ready` is high, and `req_err`, `req_done` and `wr_ready` are low.
- R9: Between any two chip-select windows, `spi_cs_n` stays high for at least `CS_GAP` clock cycles.
- R10: `spi_sck` idles low and only pulses while `spi_cs_n` is low. Each bit cell is one low cycle followed by one high cycle, and the flash samples on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_mode | input | 2 | Program flavour: 0 single, 1 dual payload, 2 dual address and payload |
| req_addr | input | 24 | Start byte address |
| req_len | input | 9 | Byte count, 1 to 256 |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| req_done | output | 1 | One-cycle pulse when programming has finished |
| wr_valid | input | 1 | Payload byte present |
| wr_data | input | 8 | Payload byte |
| wr_ready | output | 1 | Payload byte is taken on this edge when valid |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_dq_out | output | 2 | Output values for DQ1 and DQ0 |
| spi_dq_oe | output | 2 | Output enables for DQ1 and DQ0 |
| spi_miso | input | 1 | Status bits returned on DQ1 |

## Verification
The hardest situation to reach is a status loop that has to go round several times while the status byte carries a set bit other than bit 0. The flash model in the bench answers the first three polls after every program with the busy bit set, and it always returns bit 7 set. A sequencer that tested the wrong bit, or stopped after a single poll, would therefore hang or finish early. A second hard case is a payload that stalls partway through a dual-line burst. The bench gets there by gating `wr_valid` in a repeating pattern during one directed request, and then compares the array byte for byte. Requests that end exactly on a page boundary, or that would run one byte past it, are also part of the vector table.

// File: rtl/flash_prog_pkg.sv
`timescale 1ns/1ps
package flash_prog_pkg;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_PROG1  = 8'h02;
    localparam logic [7:0] OPC_PROG2D = 8'hA2;
    localparam logic [7:0] OPC_PROG2A = 8'hD2;
    localparam logic [7:0] OPC_STATUS = 8'h05;

    localparam logic [1:0] FLV_SINGLE = 2'd0;
    localparam logic [1:0] FLV_DUAL_D = 2'd1;
    localparam logic [1:0] FLV_DUAL_A = 2'd2;
    localparam logic [1:0] FLV_UNUSED = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_PROG,
        ST_STAT,
        ST_GAP
    } seq_st_e;

    function automatic logic [7:0] prog_opcode(input logic [1:0] flv);
        case (flv)
            FLV_DUAL_D: return OPC_PROG2D;
            FLV_DUAL_A: return OPC_PROG2A;
            default:    return OPC_PROG1;
        endcase
    endfunction

endpackage

// File: rtl/flash_req_check.sv
`timescale 1ns/1ps
module flash_req_check #(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 9
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              bad
);
    import flash_prog_pkg::*;

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam logic [LEN_W:0] PAGE_LIM = (LEN_W+1)'(PAGE_BYTES);

    logic [LEN_W:0] end_off;

    always_comb begin
        end_off = {{(LEN_W+1-PG_W){1'b0}}, addr[PG_W-1:0]} + {1'b0, len};
        bad = (mode == FLV_UNUSED) || (len == '0) ||
              ({1'b0, len} > PAGE_LIM) || (end_off > PAGE_LIM);
    end

endmodule

// File: rtl/flash_lane_shifter.sv
`timescale 1ns/1ps
module flash_lane_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dual,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       sck,
    output logic [1:0] dq_out,
    output logic       dual_act,
    output logic [7:0] rx
);
    typedef struct packed {
        logic       busy;
        logic       ph;
        logic       dual;
        logic [3:0] left;
        logic [7:0] sh;
        logic [7:0] rx;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.ph   = 1'b0;
                d.dual = dual;
                d.left = dual ? 4'd4 : 4'd8;
                d.sh   = tx;
            end
        end else if (!q.ph) begin
            d.ph = 1'b1;
        end else begin
            d.ph = 1'b0;
            if (!q.dual) begin
                d.rx = {q.rx[6:0], miso};
            end
            d.sh   = q.dual ? {q.sh[5:0], 2'b00} : {q.sh[6:0], 1'b0};
            d.left = q.left - 4'd1;
            if (q.left == 4'd1) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign sck      = q.busy & q.ph;
    assign dq_out   = q.dual ? {q.sh[7], q.sh[6]} : {1'b0, q.sh[7]};
    assign dual_act = q.busy & q.dual;
    assign rx       = q.rx;

endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq #(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = $clog2(PAGE_BYTES) + 1,
    parameter int CS_GAP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    output logic              req_done,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [1:0]        spi_dq_out,
    output logic [1:0]        spi_dq_oe,
    input  logic              spi_miso
);
    import flash_prog_pkg::*;

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int HDR        = 1 + ADDR_BYTES;
    localparam int IDX_W      = LEN_W + 1;
    localparam int GAP_W      = $clog2(CS_GAP + 1);

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           nxt;
        logic [GAP_W-1:0]  gap;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        mode;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              cs_n;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic             req_bad;
    logic             sh_start, sh_dual, sh_busy, sh_dual_act, sh_sck;
    logic [7:0]       sh_tx, sh_rx, abyte;
    logic [1:0]       sh_dq;
    logic [IDX_W-1:0] tot;
    logic             active, need, is_data, is_addr, rdy_c;

    flash_req_check #(
        .PAGE_BYTES(PAGE_BYTES),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_check (
        .mode(req_mode),
        .addr(req_addr),
        .len (req_len),
        .bad (req_bad)
    );

    flash_lane_shifter u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .dual    (sh_dual),
        .tx      (sh_tx),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .sck     (sh_sck),
        .dq_out  (sh_dq),
        .dual_act(sh_dual_act),
        .rx      (sh_rx)
    );

    always_comb begin
        d      = q;
        d.err  = 1'b0;
        d.done = 1'b0;
        active = (q.st == ST_WREN) || (q.st == ST_PROG) || (q.st == ST_STAT);
        case (q.st)
            ST_WREN: tot = IDX_W'(1);
            ST_PROG: tot = IDX_W'(HDR) + IDX_W'(q.len);
            ST_STAT: tot = IDX_W'(2);
            default: tot = '0;
        endcase
        need     = q.idx < tot;
        is_data  = (q.st == ST_PROG) && (q.idx >= IDX_W'(HDR));
        is_addr  = (q.st == ST_PROG) && (q.idx != '0) && !is_data;
        rdy_c    = active && !sh_busy && need && is_data;
        sh_start = active && !sh_busy && need && (!is_data || wr_valid);
        sh_dual  = (is_addr && (q.mode == FLV_DUAL_A)) ||
                   (is_data && (q.mode != FLV_SINGLE));
        abyte    = 8'(q.addr >> (8 * (ADDR_BYTES - int'(q.idx))));
        case (q.st)
            ST_WREN: sh_tx = OPC_WREN;
            ST_STAT: sh_tx = (q.idx == '0) ? OPC_STATUS : 8'h00;
            ST_PROG: sh_tx = (q.idx == '0) ? prog_opcode(q.mode) :
                             (is_data ? wr_data : abyte);
            default: sh_tx = 8'h00;
        endcase
        if (sh_start) begin
            d.idx = q.idx + IDX_W'(1);
        end
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.mode = req_mode;
                        d.addr = req_addr;
                        d.len  = req_len;
                        d.idx  = '0;
                        d.st   = ST_WREN;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == '0) begin
                    d.st = q.nxt;
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
            default: begin
                if (active && !sh_busy && !need) begin
                    d.idx = '0;
                    d.st  = ST_GAP;
                    d.gap = GAP_W'(CS_GAP - 1);
                    case (q.st)
                        ST_WREN: d.nxt = ST_PROG;
                        ST_PROG: d.nxt = ST_STAT;
                        default: begin
                            if (sh_rx[0]) begin
                                d.nxt = ST_STAT;
                            end else begin
                                d.nxt  = ST_IDLE;
                                d.done = 1'b1;
                            end
                        end
                    endcase
                end
            end
        endcase
        d.cs_n = !((d.st == ST_WREN) || (d.st == ST_PROG) || (d.st == ST_STAT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.nxt  <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign req_err    = q.err;
    assign req_done   = q.done;
    assign wr_ready   = rdy_c;
    assign spi_sck    = sh_sck;
    assign spi_cs_n   = q.cs_n;
    assign spi_dq_out = sh_dq;
    assign spi_dq_oe  = {sh_dual_act, !q.cs_n};

endmodule

// File: rtl/flash_prog_seq_chk.sv
`timescale 1ns/1ps
module flash_prog_seq_chk #(
    parameter int LEN_W  = 9,
    parameter int CS_GAP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             req_err,
    input logic             req_done,
    input logic             wr_ready,
    input logic             spi_sck,
    input logic             spi_cs_n
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 8'(CS_GAP);
        end else if (!spi_cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 8'hFF) begin
            hi_cnt <= hi_cnt + 8'd1;
        end
    end

    assert_sck_inside_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    assert_cs_high_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= 8'(CS_GAP)));

    assert_zero_len_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == '0)) |=> (req_err && spi_cs_n));

    assert_err_no_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (spi_cs_n && !wr_ready));

    assert_data_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);

    assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    assert_done_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (spi_cs_n && !req_ready && !req_err));

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .LEN_W (LEN_W),
    .CS_GAP(CS_GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_len  (req_len),
    .req_err  (req_err),
    .req_done (req_done),
    .wr_ready (wr_ready),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;

    localparam int NVEC = 10;
    localparam int BUSY_POLLS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = 2'd0;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic        req_err, req_done;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic        wr_ready;
    logic        spi_sck, spi_cs_n, spi_miso;
    logic [1:0]  spi_dq_out, spi_dq_oe;

    always #2.5 clk = ~clk;

    flash_prog_seq u_flash_prog_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_addr(req_addr), .req_len(req_len),
        .req_err(req_err), .req_done(req_done),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_dq_out(spi_dq_out), .spi_dq_oe(spi_dq_oe), .spi_miso(spi_miso)
    );

    // ---------------- write stream source ----------------
    int   cur_r = 0;
    int   k = 0;
    logic k_clr = 1'b0;
    logic stream_on = 1'b0;
    logic stall = 1'b0;
    logic [2:0] cyc = '0;

    function automatic logic [7:0] gen(input int r, input int i);
        return 8'(i * 13 + r * 29 + 7);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 3'd1;
        if (k_clr) k <= 0;
        else if (wr_valid && wr_ready) k <= k + 1;
    end
    assign wr_valid = stream_on && (!stall || (cyc[1] && cyc[0]));
    assign wr_data  = gen(cur_r, k);

    // ---------------- flash model ----------------
    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];
    logic [7:0] pbuf [300];
    logic       cs_prev = 1'b1, sck_prev = 1'b0;
    int   byte_idx, nbits, ndata, hi_run = 10, min_hi = 1000;
    logic [7:0] cur, opc, stat_sh, prev_opc = 8'h00;
    logic [23:0] paddr;
    logic wel = 1'b0;
    int   busy_polls = 0;
    int   n_wren = 0, n_prog = 0, n_stat = 0, n_txn = 0, bad_prog = 0;
    int   viol = 0, sck_bad = 0;
    logic [7:0]  last_opc;
    logic [23:0] last_addr;
    int   last_ndata;

    initial spi_miso = 1'b0;

    function automatic int lanes_now(input int bi, input logic [7:0] op);
        if (bi == 0) return 1;
        if (op == 8'hD2 && bi <= 3) return 2;
        if ((op == 8'hA2 || op == 8'hD2) && bi >= 4) return 2;
        return 1;
    endfunction

    task automatic byte_done(input logic [7:0] b);
        if (byte_idx == 0) begin
            opc = b;
            if (busy_polls > 0 && b != 8'h05) viol++;
            if (b == 8'h05) stat_sh = {1'b1, 5'b0, wel, busy_polls != 0};
        end else if (byte_idx <= 3) begin
            paddr = {paddr[15:0], b};
        end else if (ndata < 300) begin
            pbuf[ndata] = b;
            ndata++;
        end
    endtask

    task automatic end_txn();
        if (byte_idx >= 1) begin
            case (opc)
                8'h06: begin wel = 1'b1; n_wren++; end
                8'h02, 8'hA2, 8'hD2: begin
                    if (wel && prev_opc == 8'h06) begin
                        for (int i = 0; i < ndata; i++)
                            mem[{paddr[9:8], 8'(paddr[7:0] + 8'(i))}] &= pbuf[i];
                        busy_polls = BUSY_POLLS;
                        wel = 1'b0;
                        n_prog++;
                        last_opc = opc; last_addr = paddr; last_ndata = ndata;
                    end else bad_prog++;
                end
                8'h05: begin n_stat++; if (busy_polls > 0) busy_polls--; end
                default: ;
            endcase
            prev_opc = opc;
        end
    endtask

    always @(negedge clk) begin
        if (spi_cs_n) begin
            if (!cs_prev) end_txn();
            if (spi_sck) sck_bad++;
            hi_run++;
        end else begin
            if (cs_prev) begin
                n_txn++;
                if (hi_run < min_hi) min_hi = hi_run;
                byte_idx = 0; nbits = 0; ndata = 0; cur = 8'h00; opc = 8'h00;
            end
            hi_run = 0;
            if (spi_sck && !sck_prev) begin
                if (lanes_now(byte_idx, opc) == 2) begin
                    cur = {cur[5:0], spi_dq_out[1], spi_dq_out[0]};
                    nbits += 2;
                end else begin
                    cur = {cur[6:0], spi_dq_out[0]};
                    nbits += 1;
                end
                if (nbits >= 8) begin
                    byte_done(cur);
                    nbits = 0;
                    byte_idx++;
                end
            end
            if (!spi_sck && sck_prev && opc == 8'h05 && byte_idx >= 1) begin
                spi_miso = stat_sh[7];
                stat_sh = {stat_sh[6:0], 1'b0};
            end
        end
        cs_prev  = spi_cs_n;
        sck_prev = spi_sck;
    end

    // ---------------- checking ----------------
    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {err, mode[1:0], addr[23:0], len[8:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 24'h000010, 9'd16},
        {1'b0, 2'd1, 24'h7A5120, 9'd32},
        {1'b0, 2'd2, 24'h0002F0, 9'd16},
        {1'b0, 2'd0, 24'h000300, 9'd256},
        {1'b1, 2'd0, 24'h000001, 9'd0},
        {1'b1, 2'd1, 24'h000050, 9'd257},
        {1'b1, 2'd2, 24'h0001F1, 9'd16},
        {1'b1, 2'd3, 24'h000000, 9'd4},
        {1'b0, 2'd2, 24'hC30010, 9'd16},
        {1'b0, 2'd1, 24'h0000FF, 9'd1}
    };

    task automatic run_req(input int r, input logic [1:0] m, input logic [23:0] a,
                           input logic [8:0] l, input bit exp_err);
        int w0, p0, s0, t0, bp0, wait_n;
        bit got_err, got_done, ready_early;
        logic [7:0] exp_opc;
        int mism;
        cur_r = r;
        k_clr = 1'b1;
        @(negedge clk);
        k_clr = 1'b0;
        stream_on = 1'b1;
        while (!req_ready) @(negedge clk);
        w0 = n_wren; p0 = n_prog; s0 = n_stat; t0 = n_txn; bp0 = bad_prog;
        req_mode = m; req_addr = a; req_len = l; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_err = 0; got_done = 0; ready_early = 0; wait_n = 0;
        while (!got_err && !got_done && wait_n < 20000) begin
            if (req_err) got_err = 1;
            if (req_done) got_done = 1;
            if (!got_err && !got_done) begin
                if (req_ready && !exp_err) ready_early = 1;
                @(negedge clk);
                wait_n++;
            end
        end
        repeat (4) @(negedge clk);
        stream_on = 1'b0;
        if (exp_err) begin
            chk(got_err && !got_done, "R5 refusal pulse", int'(got_err), 1);
            chk(n_txn == t0, "R5 no bus window", n_txn - t0, 0);
            chk(k == 0, "R5 no stream byte taken", k, 0);
        end else begin
            exp_opc = (m == 2'd1) ? 8'hA2 : (m == 2'd2) ? 8'hD2 : 8'h02;
            for (int i = 0; i < int'(l); i++)
                exp_mem[{a[9:8], 8'(a[7:0] + 8'(i))}] &= gen(r, i);
            chk(got_done && !got_err, "R7 completion pulse", int'(got_done), 1);
            chk(!ready_early, "R7 ready low while busy", int'(ready_early), 0);
            chk(n_wren - w0 == 1 && bad_prog == bp0 && n_prog - p0 == 1,
                "R1 write enable before program", n_prog - p0, 1);
            chk(last_opc == exp_opc, "R2 program opcode", last_opc, exp_opc);
            chk(last_addr == a, "R2 R3 address bytes", last_addr, a);
            chk(last_ndata == int'(l) && k == int'(l), "R4 payload count", last_ndata, l);
            chk(n_stat - s0 == BUSY_POLLS + 1, "R6 status poll count", n_stat - s0, BUSY_POLLS + 1);
            mism = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) mism++;
            chk(mism == 0, "R4 array contents", mism, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R8 bus idle in reset", spi_cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R8 ready after reset", req_ready, 1);
        chk(req_err === 1'b0 && req_done === 1'b0 && wr_ready === 1'b0,
            "R8 pulses low after reset", {req_err, req_done, wr_ready}, 0);

        for (int v = 0; v < NVEC; v++)
            run_req(v, VEC[v][34:33], VEC[v][32:9], VEC[v][8:0], VEC[v][35]);

        // stalled dual-line payload
        stall = 1'b1;
        run_req(20, 2'd1, 24'h000200, 9'd40, 1'b0);
        stall = 1'b0;

        chk(viol == 0, "R7 no command while busy", viol, 0);
        chk(min_hi >= 2, "R9 chip-select high time", min_hi, 2);
        chk(sck_bad == 0, "R10 clock only inside window", sck_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule